// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Port

This block hands a latched conversion result to a host over a single serial data line. The host supplies a shift clock; the port puts the most significant bit on the line first and moves to the next bit on each rising edge of that clock, so the host samples on the falling edge. A chain input is captured on every falling edge and appended behind the local bits. Several ports can therefore be cascaded, each one's output feeding the next one's chain input, and one host line reads all results in turn. The port drives the line only when serial mode is selected and both the active-low select and read strobes are low. Otherwise it reports the line as released through an output-enable flag. A format input chooses offset binary, or two's complement by inverting only the top bit.

The shift clock, select and read lines are sampled on the system clock `clk`, and edges of the shift clock are found by comparison with the previous sample. A control state machine has four states. `ST_IDLE`: the port is disabled, and the shift register reloads every cycle from the held result. `ST_ARMED`: the port is enabled, but no falling shift-clock edge has been seen yet, so rising edges are ignored. `ST_SHIFT`: local bits are moving out. `ST_CHAIN`: all local bits have left, and chain bits follow.

The transitions are as follows. Every state goes to `ST_IDLE` when the enable condition drops. `ST_IDLE` goes to `ST_ARMED` when the port becomes enabled. `ST_ARMED` goes to `ST_SHIFT` on the first falling edge. `ST_SHIFT` goes to `ST_CHAIN` on the sixteenth shift. `ST_CHAIN` stays in `ST_CHAIN` on further shifts. A new result arriving during a read is held back until the port returns to `ST_IDLE`.

Top module: `serial_result_port`

## Requirements
- R1: While a read is active, the bit on `sdo` is replaced by the next lower bit at each rising edge of `shift_clk`, starting from bit 15 of the formatted word. The value seen just before each falling edge is the current bit.
- R2: `sdo_oe` is 1 exactly when `ser_mode`=1, `cs_n`=0 and `rd_n`=0. Whenever `sdo_oe` is 0, `sdo` is 0.
- R3: After the port is enabled, rising edges of `shift_clk` that come before the first falling edge do not advance the data. Bit 15 stays on `sdo` until the first rising edge that follows the first falling edge.
- R4: `chain_in` is captured at each falling edge of `shift_clk`. The bit captured at the k-th falling edge (k from 1) is on `sdo` during the (16+k)-th bit period. The first chain bit therefore follows directly after local bit 0.
- R5: With `fmt_offset`=1 the word leaves unchanged. With `fmt_offset`=0, bit 15 is inverted and bits 14..0 are unchanged. The format is taken when the read starts.
- R6: Dropping the enable condition ends the read. The next read starts again at bit 15 of the same held result.
- R7: A `conv_done` pulse while the port is idle replaces the held result, and the next read shows it. A pulse during a read does not alter the bits of that read. Its word becomes the held result once the port is idle again.
- R8: After reset the held result is 0x0000, so a read with `fmt_offset`=1 gives sixteen zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | 1 selects the serial port |
| fmt_offset | input | 1 | 1 offset binary, 0 two's complement |
| conv_done | input | 1 | One-cycle pulse: new result on conv_word |
| conv_word | input | 16 | Conversion result, offset binary |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| shift_clk | input | 1 | Host shift clock, sampled level |
| chain_in | input | 1 | Serial data from an upstream port |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The assertions take for granted that `shift_clk` is low whenever a read begins. They also take for granted that each level of `shift_clk` lasts at least one `clk` cycle, so one sample never shows both edges. Finally, they assume `conv_done` does not pulse on the same cycle the port becomes enabled. The stimulus keeps the shift clock low between reads and holds each of its phases for two system clocks. It changes select and read only while the shift clock is low, and it places conversion pulses at least three cycles away from any read start. Inside these limits, a behavioural model in the bench, built from a bit queue, predicts `sdo` and `sdo_oe` on every clock.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_CHAIN = 2'd3
    } port_state_t;
endpackage

// File: rtl/srp_edge_detect.sv
module srp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_in;
    end

    assign rise = level_in & ~prev_q;
    assign fall = ~level_in & prev_q;
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic        sc_rise,
    input  logic        sc_fall,
    output port_state_t state,
    output logic        do_load,
    output logic        do_cap,
    output logic        do_shift
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    port_state_t state_nx;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!port_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_ARMED;
                ST_ARMED: if (sc_fall) state_nx = ST_SHIFT;
                ST_SHIFT: if (sc_rise && cnt_q == LAST) state_nx = ST_CHAIN;
                ST_CHAIN: state_nx = ST_CHAIN;
            endcase
        end
    end

    always_comb begin
        do_load  = 1'b0;
        do_cap   = 1'b0;
        do_shift = 1'b0;
        unique case (state)
            ST_IDLE:  do_load = 1'b1;
            ST_ARMED: do_cap  = port_en & sc_fall;
            ST_SHIFT: begin
                do_cap   = port_en & sc_fall;
                do_shift = port_en & sc_rise;
            end
            ST_CHAIN: begin
                do_cap   = port_en & sc_fall;
                do_shift = port_en & sc_rise;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (state == ST_IDLE)         cnt_q <= '0;
        else if (do_shift && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assert_drop_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> state == ST_IDLE);

    assert_armed_ignores_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && port_en && sc_rise) |=> state == ST_ARMED);

    assert_chain_after_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CHAIN |-> cnt_q == LAST);
endmodule

// File: rtl/srp_result_latch.sv
module srp_result_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    output logic [DATA_W-1:0] held
);
    logic [DATA_W-1:0] pend_q;
    logic              pend_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held     <= '0;
            pend_q   <= '0;
            pend_vld <= 1'b0;
        end else if (conv_done) begin
            if (idle) begin
                held     <= conv_word;
                pend_vld <= 1'b0;
            end else begin
                pend_q   <= conv_word;
                pend_vld <= 1'b1;
            end
        end else if (idle && pend_vld) begin
            held     <= pend_q;
            pend_vld <= 1'b0;
        end
    end

    assert_hold_during_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(held));
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic              do_cap,
    input  logic              do_shift,
    input  logic              fmt_offset,
    input  logic [DATA_W-1:0] held,
    input  logic              chain_in,
    output logic              msb
);
    logic [DATA_W-1:0] sreg;
    logic              cap_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (do_load) begin
            sreg <= {held[DATA_W-1] ^ ~fmt_offset, held[DATA_W-2:0]};
        end else if (do_shift) begin
            sreg <= {sreg[DATA_W-2:0], cap_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_bit <= 1'b0;
        else if (do_cap) cap_bit <= chain_in;
    end

    assign msb = sreg[DATA_W-1];

    assert_shift_moves_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        do_shift |=> sreg[DATA_W-1] == $past(sreg[DATA_W-2]));

    assert_chain_enters_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_shift |=> sreg[0] == $past(cap_bit));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              fmt_offset,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              shift_clk,
    input  logic              chain_in,
    output logic              sdo,
    output logic              sdo_oe
);
    logic              port_en;
    logic              sc_rise, sc_fall;
    logic              do_load, do_cap, do_shift;
    logic              msb;
    logic [DATA_W-1:0] held;
    port_state_t       state;

    assign port_en = ser_mode & ~cs_n & ~rd_n;

    srp_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(shift_clk),
        .rise(sc_rise), .fall(sc_fall)
    );

    srp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .sc_rise(sc_rise), .sc_fall(sc_fall), .state(state),
        .do_load(do_load), .do_cap(do_cap), .do_shift(do_shift)
    );

    srp_result_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .idle(do_load),
        .conv_done(conv_done), .conv_word(conv_word), .held(held)
    );

    srp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_cap(do_cap),
        .do_shift(do_shift), .fmt_offset(fmt_offset), .held(held),
        .chain_in(chain_in), .msb(msb)
    );

    assign sdo_oe = port_en;
    assign sdo    = port_en & msb;

    assert_enabled_means_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> (state != ST_IDLE) || !port_en);
endmodule

// File: tb/serial_result_port_test.sv
module serial_result_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_mode = 1'b1, fmt_offset = 1'b1, conv_done = 1'b0;
    logic [15:0] conv_word = '0;
    logic cs_n = 1'b1, rd_n = 1'b1, shift_clk = 1'b0, chain_in = 1'b0;
    logic sdo, sdo_oe;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serial_result_port uut (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .fmt_offset(fmt_offset),
        .conv_done(conv_done), .conv_word(conv_word), .cs_n(cs_n), .rd_n(rd_n),
        .shift_clk(shift_clk), .chain_in(chain_in), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // behavioural reference model
    logic m_q[$];
    bit   m_read = 0, m_seen = 0, m_cap = 0, m_prev = 0, m_pv = 0;
    logic [15:0] m_held = '0, m_pend = '0;

    always @(posedge clk) begin
        bit en, rs, fl, was_read;
        logic [15:0] w;
        if (!rst_n) begin
            m_q.delete(); m_read = 0; m_seen = 0; m_cap = 0; m_prev = 0;
            m_pv = 0; m_held = '0; m_pend = '0;
        end else begin
            en = ser_mode && !cs_n && !rd_n;
            rs = shift_clk && !m_prev;
            fl = !shift_clk && m_prev;
            was_read = m_read;
            if (!m_read) begin
                if (en) begin
                    w = m_held;
                    if (!fmt_offset) w[15] = ~w[15];
                    m_q.delete();
                    for (int b = 15; b >= 0; b--) m_q.push_back(w[b]);
                    m_read = 1; m_seen = 0;
                end
            end else if (!en) begin
                m_read = 0;
            end else begin
                if (fl) begin m_cap = chain_in; m_seen = 1; end
                if (rs && m_seen) begin
                    void'(m_q.pop_front());
                    m_q.push_back(m_cap);
                end
            end
            if (conv_done) begin
                if (!was_read) begin m_held = conv_word; m_pv = 0; end
                else begin m_pend = conv_word; m_pv = 1; end
            end else if (!was_read && m_pv) begin
                m_held = m_pend; m_pv = 0;
            end
            m_prev = shift_clk;
        end
    end

    always begin
        @(posedge clk); #1;
        if (rst_n) begin
            bit en;
            en = ser_mode && !cs_n && !rd_n;
            chk("R2 oe", {31'd0, sdo_oe}, {31'd0, en});
            chk("R1 sdo model", {31'd0, sdo}, {31'd0, (en && m_q.size() > 0) ? m_q[0] : 1'b0});
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic new_result(input logic [15:0] w);
        @(negedge clk); conv_done = 1; conv_word = w;
        @(negedge clk); conv_done = 0;
    endtask

    task automatic start_read();
        @(negedge clk); cs_n = 0; rd_n = 0;
        clocks(2);
    endtask

    task automatic end_read();
        @(negedge clk); cs_n = 1; rd_n = 1; shift_clk = 0;
        clocks(3);
    endtask

    task automatic shift_bits(input int n, input logic [15:0] chain, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); shift_clk = 1;
            clocks(1);
            @(posedge clk); #1; got[31-i] = sdo;
            @(negedge clk); shift_clk = 0; chain_in = (i < 16) ? chain[15-i] : 1'b0;
            clocks(1);
        end
    endtask

    initial begin
        logic [31:0] g;
        clocks(3);
        rst_n = 1;
        clocks(2);
        chk("R8 reset oe", {31'd0, sdo_oe}, 32'd0);
        chk("R8 reset sdo", {31'd0, sdo}, 32'd0);

        // R8: result after reset is zero
        start_read();
        shift_bits(16, 16'h0000, g);
        chk("R8 zero word", g, 32'h0);
        end_read();

        // R1 R4: full daisy read, offset binary
        new_result(16'hA5C3);
        clocks(3);
        start_read();
        shift_bits(32, 16'h3C96, g);
        chk("R1 local word", {16'd0, g[31:16]}, 32'h0000A5C3);
        chk("R4 chain bits follow", {16'd0, g[15:0]}, 32'h00003C96);
        end_read();

        // R5: two's complement inverts only MSB
        fmt_offset = 0;
        start_read();
        shift_bits(16, 16'h0000, g);
        chk("R5 twos complement", {16'd0, g[31:16]}, 32'h000025C3);
        end_read();
        fmt_offset = 1;

        // R3: rising edge before any falling edge keeps bit 15
        start_read();
        @(negedge clk); shift_clk = 1;
        clocks(3);
        @(posedge clk); #1;
        chk("R3 bit15 held", {31'd0, sdo}, 32'd1);
        end_read();

        // R6: aborted read restarts at MSB
        start_read();
        shift_bits(5, 16'h0000, g);
        chk("R6 partial", {27'd0, g[31:27]}, {27'd0, 5'b10100});
        end_read();
        start_read();
        shift_bits(16, 16'h0000, g);
        chk("R6 restart at MSB", {16'd0, g[31:16]}, 32'h0000A5C3);
        end_read();

        // R2: mode low or read high keeps output released
        ser_mode = 0;
        @(negedge clk); cs_n = 0; rd_n = 0;
        clocks(2); @(posedge clk); #1;
        chk("R2 mode low oe", {30'd0, sdo_oe, sdo}, 32'd0);
        end_read();
        ser_mode = 1;
        @(negedge clk); cs_n = 0; rd_n = 1;
        clocks(2); @(posedge clk); #1;
        chk("R2 read high oe", {30'd0, sdo_oe, sdo}, 32'd0);
        end_read();

        // R7: result arriving during a read is deferred
        start_read();
        shift_bits(4, 16'h0000, g);
        new_result(16'h1234);
        begin
            logic [31:0] g2;
            shift_bits(12, 16'h0000, g2);
            chk("R7 read not corrupted", {16'd0, g[31:28], g2[31:20]}, 32'h0000A5C3);
        end
        end_read();
        start_read();
        shift_bits(16, 16'h0000, g);
        chk("R7 deferred word", {16'd0, g[31:16]}, 32'h00001234);
        end_read();

        // R5: two's complement on a word with MSB clear
        fmt_offset = 0;
        start_read();
        shift_bits(16, 16'h0000, g);
        chk("R5 msb set by inversion", {16'd0, g[31:16]}, 32'h00009234);
        end_read();

        clocks(4);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end
endmodule